// File: doc/BRIEF.md
# Watchdog Timer with Dual-Clear Option

This block supervises software progress. It counts ticks from one of three selectable time sources and, if software fails to restart it before the count reaches a selectable terminal value, raises a one-cycle reset request together with a sticky time-out flag. Software restarts the count by issuing clear strobes, which arrive as one-cycle pulses from the instruction-decode logic. There are two strobe types, A and B.

Static option inputs fix the configuration: a global enable, the tick source, the terminal stage and the clear discipline. In single-clear mode either strobe restarts the count. In dual-clear mode the count restarts only once both strobe types have been seen, so a single stray instruction cannot keep the timer alive. The whole block runs on the system clock. The oscillator inputs are synchronised and edge-detected into one-cycle tick enables.

Two state machines carry the behaviour. The clear tracker has the states CLR_IDLE, CLR_HOLD_A and CLR_HOLD_B. It moves from idle to a hold state when one strobe type arrives in dual mode, and it fires and returns to idle when the other type arrives. Both types in the same cycle fire directly from idle. A time-out or the disable option sends it back to idle. The count sequencer has the states WD_OFF, WD_RUN and WD_FIRE. It goes from off to run when enabled and from run to fire on a terminal tick that no clear pre-empts. It always leaves fire after one cycle, going back to run, or to off if disabled.

Top module: `wdog_dualclr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count, both pending clear states and the time-out flag; `tmo_rst` and `tmo_flag` read 0 after it.
- R2: `opt_src` picks the tick: 0 = system clock divided by SYS_DIV (default 4), 1 = rising edges of `rtc_osc`, 2 or 3 = rising edges of `wdt_osc`; the count advances by one per tick.
- R3: `opt_stage` value s (0..3) sets the time-out to 2^(STAGE_LO+s) ticks after the count last restarted from zero.
- R4: A time-out drives `tmo_rst` high for exactly one cycle, returns the count to zero and lets counting resume, so time-outs repeat at the same interval while no clear arrives.
- R5: `tmo_flag` is set in the same cycle as the `tmo_rst` pulse and stays set until reset.
- R6: While `opt_enable` is 0 the count is held at zero and no time-out occurs.
- R7: With `opt_dual` = 0, a pulse on either `clr_a` or `clr_b` restarts the count from zero.
- R8: With `opt_dual` = 1, the count restarts when both strobe types have been seen, in either order or in the same cycle; the pending state then returns to idle.
- R9: With `opt_dual` = 1, a lone strobe type, however often repeated, does not restart the count.
- R10: A time-out discards any pending strobe in dual mode, and so does a strobe arriving during the pulse cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| opt_enable | input | 1 | Static option: 1 enables the watchdog |
| opt_src | input | 2 | Static option: tick source select |
| opt_dual | input | 1 | Static option: 1 selects dual-clear mode |
| opt_stage | input | 2 | Static option: terminal stage select |
| rtc_osc | input | 1 | Real-time-clock oscillator level, asynchronous |
| wdt_osc | input | 1 | Dedicated watchdog oscillator level, asynchronous |
| clr_a | input | 1 | Clear strobe of type A, one cycle |
| clr_b | input | 1 | Clear strobe of type B, one cycle |
| tmo_rst | output | 1 | One-cycle time-out reset request |
| tmo_flag | output | 1 | Sticky time-out flag |

## Verification
The properties assume that the option inputs change only while reset is held. They also assume that each oscillator input stays in each level for at least one system cycle, so that the synchroniser sees every edge. The stimulus sets all options inside its reset task and toggles the oscillators on falling clock edges, with periods of two and six cycles. Clear strobes are always single-cycle pulses applied between edges. Expected time-out cycles carry a small tolerance to absorb synchroniser latency and tick phase.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int NSTAGE     = 4;
    localparam int STAGE_SELW = 2;

    typedef enum logic [1:0] {
        SRC_SYS_DIV = 2'd0,
        SRC_RTC     = 2'd1,
        SRC_WOSC    = 2'd2,
        SRC_WOSC_B  = 2'd3
    } wdg_src_e;

    typedef enum logic [1:0] {
        CLR_IDLE   = 2'd0,
        CLR_HOLD_A = 2'd1,
        CLR_HOLD_B = 2'd2
    } clr_state_e;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen
    import wdg_pkg::*;
#(
    parameter int SYS_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src,
    input  logic       rtc_osc,
    input  logic       wdt_osc,
    output logic       tick
);
    localparam int DIV_W = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             sys_tick;
    logic [1:0]       osc_in;
    logic [1:0]       osc_rise;

    // free-running divider of the system clock
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign sys_tick = (div_q == DIV_LAST);
    assign osc_in   = {wdt_osc, rtc_osc};

    // one synchroniser and edge detector per oscillator input
    for (genvar g = 0; g < 2; g++) begin : g_osc
        logic [SYNC_STAGES-1:0] sh_q;
        logic                   last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '0;
                last_q <= 1'b0;
            end else begin
                sh_q   <= {sh_q[SYNC_STAGES-2:0], osc_in[g]};
                last_q <= sh_q[SYNC_STAGES-1];
            end
        end

        assign osc_rise[g] = sh_q[SYNC_STAGES-1] & ~last_q;
    end

    always_comb begin
        unique case (wdg_src_e'(src))
            SRC_SYS_DIV: tick = sys_tick;
            SRC_RTC:     tick = osc_rise[0];
            SRC_WOSC,
            SRC_WOSC_B:  tick = osc_rise[1];
            default:     tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdg_clear_fsm.sv
module wdg_clear_fsm
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       dual,
    input  logic       flush,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       fire,
    output clr_state_e state
);
    clr_state_e state_q;
    clr_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CLR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable || !dual || flush) begin
            state_d = CLR_IDLE;
        end else begin
            unique case (state_q)
                CLR_IDLE: begin
                    if (clr_a && !clr_b) begin
                        state_d = CLR_HOLD_A;
                    end else if (clr_b && !clr_a) begin
                        state_d = CLR_HOLD_B;
                    end
                end
                CLR_HOLD_A: if (clr_b) state_d = CLR_IDLE;
                CLR_HOLD_B: if (clr_a) state_d = CLR_IDLE;
                default:    state_d = CLR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        if (enable && !flush) begin
            if (!dual) begin
                fire = clr_a | clr_b;
            end else begin
                unique case (state_q)
                    CLR_IDLE:   fire = clr_a & clr_b;
                    CLR_HOLD_A: fire = clr_b;
                    CLR_HOLD_B: fire = clr_a;
                    default:    fire = 1'b0;
                endcase
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/wdg_count_fsm.sv
module wdg_count_fsm
    import wdg_pkg::*;
#(
    parameter int STAGE_LO = 13,
    localparam int CNT_W   = STAGE_LO + NSTAGE - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [STAGE_SELW-1:0] stage,
    input  logic                  tick,
    input  logic                  clr_fire,
    output logic                  tmo_pulse,
    output logic                  tmo_flag,
    output logic [CNT_W-1:0]      cnt,
    output wd_state_e             state
);
    wd_state_e        state_q;
    wd_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_tab [NSTAGE];
    logic [CNT_W-1:0] term_sel;
    logic             hit;
    logic             flag_q;

    // terminal value of each stage: 2^(STAGE_LO+g) - 1
    for (genvar g = 0; g < NSTAGE; g++) begin : g_term
        assign term_tab[g] = {CNT_W{1'b1}} >> (NSTAGE - 1 - g);
    end

    assign term_sel = term_tab[stage];
    assign hit      = tick && (cnt_q == term_sel) && !clr_fire;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (enable) state_d = WD_RUN;
            WD_RUN: begin
                if (!enable) begin
                    state_d = WD_OFF;
                end else if (hit) begin
                    state_d = WD_FIRE;
                end
            end
            WD_FIRE: state_d = enable ? WD_RUN : WD_OFF;
            default: state_d = WD_OFF;
        endcase
    end

    // count and sticky flag
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (state_q != WD_RUN || clr_fire || hit) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == WD_RUN && state_d == WD_FIRE) begin
                flag_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tmo_pulse = (state_q == WD_FIRE);
        tmo_flag  = flag_q;
        cnt       = cnt_q;
        state     = state_q;
    end

endmodule

// File: rtl/wdog_dualclr.sv
module wdog_dualclr
    import wdg_pkg::*;
#(
    parameter int STAGE_LO    = 13,
    parameter int SYS_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       opt_enable,
    input  logic [1:0] opt_src,
    input  logic       opt_dual,
    input  logic [1:0] opt_stage,
    input  logic       rtc_osc,
    input  logic       wdt_osc,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       tmo_rst,
    output logic       tmo_flag
);
    localparam int CNT_W = STAGE_LO + NSTAGE - 1;

    logic             tick;
    logic             clr_fire;
    logic [CNT_W-1:0] cnt_val;
    clr_state_e       clr_st;
    wd_state_e        wd_st;
    logic             flush;

    assign flush = (wd_st == WD_FIRE);

    wdg_tick_gen #(
        .SYS_DIV     (SYS_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .src     (opt_src),
        .rtc_osc (rtc_osc),
        .wdt_osc (wdt_osc),
        .tick    (tick)
    );

    wdg_clear_fsm u_clr (
        .clk    (clk),
        .rst    (rst),
        .enable (opt_enable),
        .dual   (opt_dual),
        .flush  (flush),
        .clr_a  (clr_a),
        .clr_b  (clr_b),
        .fire   (clr_fire),
        .state  (clr_st)
    );

    wdg_count_fsm #(
        .STAGE_LO (STAGE_LO)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (opt_enable),
        .stage     (opt_stage),
        .tick      (tick),
        .clr_fire  (clr_fire),
        .tmo_pulse (tmo_rst),
        .tmo_flag  (tmo_flag),
        .cnt       (cnt_val),
        .state     (wd_st)
    );

endmodule

// File: rtl/wdog_dualclr_chk.sv
module wdog_dualclr_chk
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             opt_enable,
    input logic             opt_dual,
    input logic             clr_a,
    input logic             clr_b,
    input logic             tmo_rst,
    input logic             tmo_flag,
    input logic             clr_fire,
    input logic [CNT_W-1:0] cnt_val,
    input logic [1:0]       clr_st
);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        tmo_rst |=> !tmo_rst);

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        tmo_rst |-> cnt_val == '0);

    p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        tmo_rst |-> tmo_flag);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |=> tmo_flag);

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!opt_enable && $past(!opt_enable)) |-> !tmo_rst);

    p_clear_restarts_r7: assert property (@(posedge clk) disable iff (rst)
        clr_fire |=> cnt_val == '0);

    p_single_no_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!opt_dual && $past(!opt_dual)) |-> clr_st == CLR_IDLE);

    p_pair_fires_r8: assert property (@(posedge clk) disable iff (rst)
        (opt_dual && opt_enable && !tmo_rst && clr_st == CLR_HOLD_A && clr_b) |-> clr_fire);

    p_fire_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (opt_dual && clr_fire) |=> clr_st == CLR_IDLE);

    p_lone_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (opt_dual && clr_st == CLR_IDLE && (clr_a ^ clr_b)) |-> !clr_fire);

    p_flush_pending_r10: assert property (@(posedge clk) disable iff (rst)
        tmo_rst |=> clr_st == CLR_IDLE);

endmodule

bind wdog_dualclr wdog_dualclr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opt_enable (opt_enable),
    .opt_dual   (opt_dual),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .tmo_rst    (tmo_rst),
    .tmo_flag   (tmo_flag),
    .clr_fire   (clr_fire),
    .cnt_val    (cnt_val),
    .clr_st     (clr_st)
);

// File: tb/wdog_dualclr_tb.sv
`timescale 1ns/1ps
module wdog_dualclr_tb;

    localparam int TOL  = 12;
    localparam int TW   = 512;   // stage 0 with watchdog oscillator (256 ticks x 2 cycles)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       opt_enable = 1'b1;
    logic [1:0] opt_src = 2'd2;
    logic       opt_dual = 1'b0;
    logic [1:0] opt_stage = 2'd0;
    logic       rtc_osc = 1'b0;
    logic       wdt_osc = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       tmo_rst;
    logic       tmo_flag;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    rtc_div = 0;
    logic  prev_tmo = 1'b0;
    bit    done = 1'b0;
    int    exp_at[$];
    string exp_tag[$];

    always #2 clk = ~clk;

    wdog_dualclr #(.STAGE_LO(8)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .opt_enable (opt_enable),
        .opt_src    (opt_src),
        .opt_dual   (opt_dual),
        .opt_stage  (opt_stage),
        .rtc_osc    (rtc_osc),
        .wdt_osc    (wdt_osc),
        .clr_a      (clr_a),
        .clr_b      (clr_b),
        .tmo_rst    (tmo_rst),
        .tmo_flag   (tmo_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // oscillator models: watchdog period 2 cycles, rtc period 6 cycles
    always @(negedge clk) begin
        wdt_osc <= ~wdt_osc;
        if (rtc_div == 2) begin
            rtc_div <= 0;
            rtc_osc <= ~rtc_osc;
        end else begin
            rtc_div <= rtc_div + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // monitor: pops expected time-outs and compares
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (tmo_rst) begin
                chk(!prev_tmo, "R4 pulse width", 2, 1);
                chk(tmo_flag, "R5 flag with pulse", int'(tmo_flag), 1);
                if (exp_at.size() == 0) begin
                    chk(1'b0, "R6/R9 unexpected time-out", cyc, -1);
                end else begin
                    int    e;
                    string t;
                    int    d;
                    e = exp_at.pop_front();
                    t = exp_tag.pop_front();
                    d = cyc - e;
                    chk((d <= TOL) && (d >= -TOL), t, cyc, e);
                end
            end
            prev_tmo <= tmo_rst;
        end else begin
            prev_tmo <= 1'b0;
        end
    end

    task automatic expect_at(input int at, input string tag);
        exp_at.push_back(at);
        exp_tag.push_back(tag);
    endtask

    task automatic drained(input string tag);
        chk(exp_at.size() == 0, tag, exp_at.size(), 0);
        exp_at.delete();
        exp_tag.delete();
    endtask

    task automatic do_reset(input logic en, input logic [1:0] src, input logic dual,
                            input logic [1:0] stage, output int ref_cyc);
        @(negedge clk);
        rst = 1'b1;
        opt_enable = en;
        opt_src = src;
        opt_dual = dual;
        opt_stage = stage;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ref_cyc = cyc;
    endtask

    task automatic strobe(input logic a, input logic b, output int when);
        @(negedge clk);
        clr_a = a;
        clr_b = b;
        when = cyc;
        @(negedge clk);
        clr_a = 1'b0;
        clr_b = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int r;
        int t;

        // R1: reset state
        do_reset(1'b1, 2'd2, 1'b0, 2'd0, r);
        @(negedge clk);
        chk(!tmo_rst, "R1 reset pulse", int'(tmo_rst), 0);
        chk(!tmo_flag, "R1 reset flag", int'(tmo_flag), 0);

        // R3/R4/R5: stage 0 on watchdog oscillator, repeated time-out
        do_reset(1'b1, 2'd2, 1'b0, 2'd0, r);
        expect_at(r + TW, "R3 stage0 wdt source");
        expect_at(r + 2 * TW, "R4 restart after time-out");
        idle(1100);
        drained("R4 both time-outs seen");
        chk(tmo_flag, "R5 sticky flag", int'(tmo_flag), 1);

        // R1: reset clears the sticky flag
        do_reset(1'b1, 2'd2, 1'b0, 2'd0, r);
        @(negedge clk);
        chk(!tmo_flag, "R1 flag cleared by reset", int'(tmo_flag), 0);

        // R2: system clock divided by 4
        do_reset(1'b1, 2'd0, 1'b0, 2'd0, r);
        expect_at(r + 1024, "R2 sys/4 source");
        idle(1100);
        drained("R2 sys/4 drained");

        // R2: rtc oscillator
        do_reset(1'b1, 2'd1, 1'b0, 2'd0, r);
        expect_at(r + 1536, "R2 rtc source");
        idle(1600);
        drained("R2 rtc drained");

        // R3: stage 1 and stage 3
        do_reset(1'b1, 2'd2, 1'b0, 2'd1, r);
        expect_at(r + 2 * TW, "R3 stage1");
        idle(1080);
        drained("R3 stage1 drained");
        do_reset(1'b1, 2'd2, 1'b0, 2'd3, r);
        expect_at(r + 8 * TW, "R3 stage3");
        idle(4150);
        drained("R3 stage3 drained");

        // R6: disabled
        do_reset(1'b0, 2'd2, 1'b0, 2'd0, r);
        idle(3000);
        chk(!tmo_flag, "R6 disabled no flag", int'(tmo_flag), 0);

        // R7: single mode, either strobe restarts
        do_reset(1'b1, 2'd2, 1'b0, 2'd0, r);
        idle(300);
        strobe(1'b1, 1'b0, t);
        idle(300);
        strobe(1'b0, 1'b1, t);
        expect_at(t + TW, "R7 single clear");
        idle(560);
        drained("R7 drained");

        // R9: dual mode, repeated A only
        do_reset(1'b1, 2'd2, 1'b1, 2'd0, r);
        idle(150);
        strobe(1'b1, 1'b0, t);
        idle(150);
        strobe(1'b1, 1'b0, t);
        expect_at(r + TW, "R9 repeated A ignored");
        idle(300);
        drained("R9 drained");

        // R8: dual mode, B then A
        do_reset(1'b1, 2'd2, 1'b1, 2'd0, r);
        idle(200);
        strobe(1'b0, 1'b1, t);
        idle(200);
        strobe(1'b1, 1'b0, t);
        expect_at(t + TW, "R8 B then A");
        idle(560);
        drained("R8 B-A drained");

        // R8: dual mode, A then B
        do_reset(1'b1, 2'd2, 1'b1, 2'd0, r);
        idle(200);
        strobe(1'b1, 1'b0, t);
        idle(200);
        strobe(1'b0, 1'b1, t);
        expect_at(t + TW, "R8 A then B");
        idle(560);
        drained("R8 A-B drained");

        // R8: dual mode, both in one cycle
        do_reset(1'b1, 2'd2, 1'b1, 2'd0, r);
        idle(400);
        strobe(1'b1, 1'b1, t);
        expect_at(t + TW, "R8 same cycle");
        idle(560);
        drained("R8 same-cycle drained");

        // R10: pending A discarded by time-out
        do_reset(1'b1, 2'd2, 1'b1, 2'd0, r);
        idle(100);
        strobe(1'b1, 1'b0, t);
        expect_at(r + TW, "R10 first time-out");
        idle(450);
        strobe(1'b0, 1'b1, t);
        expect_at(r + 2 * TW, "R10 pending flushed");
        idle(520);
        drained("R10 drained");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule